// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel transfer engine that copies data items from a source pointer to a destination pointer over a request/response memory port. Each item is one read followed by one write of 1, 2 or 4 bytes. The channel is programmed while idle by pulsing a load strobe. The load captures a 32-bit settings word, a source and a destination start address, an offset used by the offset address mode, a 16-bit item length and a 16-bit block count.

Work is started by hardware triggers or by a software start. The mode decides how much work one activation does and what happens when a group of items completes. In normal mode the channel runs once through the length. Repeat mode reloads the length for a programmed number of rounds. Block mode moves a whole block per activation. In ring-of-blocks mode the block sequence restarts for ever. One pointer can be named the repeat area; it snaps back to its start at each group boundary while the other pointer keeps advancing. An enable input gates all activity. Activations that arrive while the engine is busy are queued in a small saturating counter.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset the memory port is idle, the interrupt is low, the error flag is low, both remaining counts read zero and the finished flag is high until a configuration is loaded.
- R2: Settings word fields: [31:30] mode (0 normal, 1 repeat, 2 block, 3 ring of blocks), [29:28] item size, [27:26] source address mode, [19:18] destination address mode, [21] interrupt select, [20] repeat area (1 = source, 0 = destination); the other bits are ignored. In normal mode each activation moves one item and lowers the remaining length by one. At zero the finished flag rises and later triggers move nothing. A request is held with a stable address until its response arrives.
- R3: Size codes 0, 1 and 2 move 1, 2 and 4 bytes, little-endian. Address mode 0 keeps a pointer fixed, 1 adds the loaded offset, 2 adds the item size and 3 subtracts it. Each pointer follows its own mode after every item.
- R4: In repeat mode each activation moves one item. When the length runs out, the length and the repeat-area pointer reload and the block count drops by one. When the block count reaches zero the channel finishes and ignores triggers.
- R5: In block mode one activation moves a whole block of length items. The repeat-area pointer then returns to its start, the length reloads and the block count drops by one. At a count of zero the channel finishes.
- R6: In ring-of-blocks mode blocks behave as in block mode. When the block count runs out it reloads, the non-repeat pointer also returns to its start, and the channel never finishes.
- R7: Interrupt select 1 gives a one-cycle interrupt pulse after every item. Select 0 gives one pulse only when the whole transfer ends (the ring wrap in ring-of-blocks mode). A pulse always follows a completed write.
- R8: While the enable input is low no new item starts and triggers are not counted; an item already underway completes.
- R9: A software start with the continuous input low acts as one trigger. With it high the channel keeps activating itself until it finishes. A software stop cancels continuous running and queued activations, and the channel halts once the current item completes.
- R10: Activations that arrive during a block are counted up to 2^PEND_W-1 and each one later runs its own block.
- R11: Size code 3 is reserved: loading it raises the error flag, and the channel issues no request until a valid configuration is loaded, which clears the flag.
- R12: Loading a length of zero, or a block count of zero in any mode other than normal, sets the finished flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Capture configuration (accepted when idle) |
| cfg_word_i | input | 32 | Settings word |
| cfg_src_i | input | ADDR_W | Source start address |
| cfg_dst_i | input | ADDR_W | Destination start address |
| cfg_offset_i | input | ADDR_W | Offset for address mode 1 |
| cfg_len_i | input | CNT_W | Items per group |
| cfg_blk_i | input | CNT_W | Block or repeat count |
| en_i | input | 1 | Channel enable gate |
| trig_i | input | 1 | Hardware activation |
| sw_start_i | input | 1 | Software start strobe |
| sw_cont_i | input | 1 | Software start runs continuously when high |
| sw_stop_i | input | 1 | Software stop strobe |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_size_o | output | 2 | Item size code |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Response for the pending request |
| mem_rdata_i | input | 32 | Read data, valid with the response |
| irq_o | output | 1 | Interrupt pulse |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | Reserved size programmed |
| len_left_o | output | CNT_W | Remaining items in the current group |
| blk_left_o | output | CNT_W | Remaining blocks or rounds |

## Verification
The bench builds the channel with ADDR_W = 12, CNT_W = 16 and PEND_W = 2. A 12-bit address space lets a 256-byte model memory answer every request, so the bench checks each moved byte, each pointer step and each snap-back at exact addresses. With a pending ceiling of three, four back-to-back triggers during a block fill the queue to its limit, and every queued block must still run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_BLOCK  = 2'd2,
    MODE_RING   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_OFFSET = 2'd1,
    AM_INC    = 2'd2,
    AM_DEC    = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic [1:0] size;
    addr_mode_e src_am;
    addr_mode_e dst_am;
    logic       irq_each;
    logic       rep_src;
  } seq_cfg_t;

  function automatic seq_cfg_t decode_cfg(input logic [31:0] w);
    seq_cfg_t c;
    c.mode     = xfer_mode_e'(w[31:30]);
    c.size     = w[29:28];
    c.src_am   = addr_mode_e'(w[27:26]);
    c.dst_am   = addr_mode_e'(w[19:18]);
    c.irq_each = w[21];
    c.rep_src  = w[20];
    return c;
  endfunction

endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  addr_mode_e    am_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] offset_i,
  input  logic          step_i,
  input  logic          restore_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] base_q, cur_q, nxt, inc_amt;

  assign inc_amt = AW'(1) << size_i;

  always_comb begin
    unique case (am_i)
      AM_FIXED:  nxt = cur_q;
      AM_OFFSET: nxt = cur_q + offset_i;
      AM_INC:    nxt = cur_q + inc_amt;
      default:   nxt = cur_q - inc_amt;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= start_i;
      cur_q  <= start_i;
    end else if (restore_i) begin
      cur_q <= base_q;
    end else if (step_i) begin
      cur_q <= nxt;
    end
  end

  assign ptr_o = cur_q;

endmodule

// File: rtl/dma_pend_ctr.sv
module dma_pend_ctr #(
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [PW-1:0] cnt_o
);

  localparam logic [PW-1:0] PMAX = '1;

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != PMAX) cnt_q <= cnt_q + PW'(1);
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - PW'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PEND_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [31:0]       cfg_word_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [ADDR_W-1:0] cfg_offset_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  input  logic [CNT_W-1:0]  cfg_blk_i,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic              sw_start_i,
  input  logic              sw_cont_i,
  input  logic              sw_stop_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rsp_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  len_left_o,
  output logic [CNT_W-1:0]  blk_left_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam int NPTR = 2; // 0 = source, 1 = destination

  seq_cfg_t         cfg_q;
  seq_state_e       st_q;
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0] len_init_q, blk_init_q, len_q, blk_q, len_nxt, blk_nxt;
  logic             fin_q, err_q, cont_q, stop_q, irq_q;
  logic [31:0]      data_q;
  logic [PEND_W-1:0] pend;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word_i[25:22], cfg_word_i[17:0]};

  logic load_ok, item_done, last_item, blk_last, blk_mode, mid_block;
  logic fin_set, end_evt, rep_rst, oth_rst;
  logic act_req, start_idle, go_on, pend_nz, pend_dec, cont_set;

  assign load_ok   = cfg_load_i && (st_q == ST_IDLE);
  assign item_done = (st_q == ST_WR) && mem_rsp_i;
  assign last_item = (len_q == CNT_ONE);
  assign blk_last  = (blk_q == CNT_ONE);
  assign blk_mode  = cfg_q.mode[1];
  assign mid_block = blk_mode && !last_item;
  assign pend_nz   = (pend != '0);

  // group bookkeeping on item completion
  always_comb begin
    len_nxt = len_q;
    blk_nxt = blk_q;
    fin_set = 1'b0;
    end_evt = 1'b0;
    rep_rst = 1'b0;
    oth_rst = 1'b0;
    if (item_done) begin
      len_nxt = len_q - CNT_ONE;
      unique case (cfg_q.mode)
        MODE_NORMAL: begin
          if (last_item) begin
            fin_set = 1'b1;
            end_evt = 1'b1;
          end
        end
        MODE_REPEAT, MODE_BLOCK: begin
          if (last_item) begin
            rep_rst = 1'b1;
            blk_nxt = blk_q - CNT_ONE;
            if (blk_last) begin
              fin_set = 1'b1;
              end_evt = 1'b1;
            end else begin
              len_nxt = len_init_q;
            end
          end
        end
        default: begin
          if (last_item) begin
            rep_rst = 1'b1;
            len_nxt = len_init_q;
            if (blk_last) begin
              blk_nxt = blk_init_q;
              oth_rst = 1'b1;
              end_evt = 1'b1;
            end else begin
              blk_nxt = blk_q - CNT_ONE;
            end
          end
        end
      endcase
    end
  end

  assign act_req    = en_i && !fin_q && !err_q && !load_ok &&
                      (trig_i || (sw_start_i && !sw_cont_i));
  assign cont_set   = en_i && !fin_q && !err_q && !load_ok && sw_start_i && sw_cont_i;
  assign start_idle = (st_q == ST_IDLE) && en_i && !fin_q && !err_q && !load_ok &&
                      !sw_stop_i && (pend_nz || cont_q);
  assign go_on      = item_done && en_i && !stop_q && !sw_stop_i && !fin_set &&
                      (mid_block || pend_nz || cont_q);
  assign pend_dec   = !cont_q && pend_nz && (start_idle || (go_on && !mid_block));

  dma_pend_ctr #(.PW(PEND_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_ok || sw_stop_i),
    .inc_i  (act_req),
    .dec_i  (pend_dec),
    .cnt_o  (pend)
  );

  logic [ADDR_W-1:0] ptr_start [NPTR];
  logic [ADDR_W-1:0] ptr_cur   [NPTR];
  addr_mode_e        ptr_am    [NPTR];
  logic              ptr_rst   [NPTR];

  assign ptr_start[0] = cfg_src_i;
  assign ptr_start[1] = cfg_dst_i;
  assign ptr_am[0]    = cfg_q.src_am;
  assign ptr_am[1]    = cfg_q.dst_am;
  assign ptr_rst[0]   = cfg_q.rep_src ? rep_rst : oth_rst;
  assign ptr_rst[1]   = cfg_q.rep_src ? oth_rst : rep_rst;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    dma_ptr_unit #(.AW(ADDR_W)) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_ok),
      .start_i   (ptr_start[gi]),
      .am_i      (ptr_am[gi]),
      .size_i    (cfg_q.size),
      .offset_i  (off_q),
      .step_i    (item_done),
      .restore_i (ptr_rst[gi]),
      .ptr_o     (ptr_cur[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      off_q      <= '0;
      len_init_q <= '0;
      blk_init_q <= '0;
      len_q      <= '0;
      blk_q      <= '0;
      fin_q      <= 1'b1;
      err_q      <= 1'b0;
      cont_q     <= 1'b0;
      stop_q     <= 1'b0;
      irq_q      <= 1'b0;
      data_q     <= '0;
      st_q       <= ST_IDLE;
    end else begin
      irq_q <= item_done && (cfg_q.irq_each || end_evt);
      if (load_ok) begin
        cfg_q      <= decode_cfg(cfg_word_i);
        off_q      <= cfg_offset_i;
        len_init_q <= cfg_len_i;
        blk_init_q <= cfg_blk_i;
        len_q      <= cfg_len_i;
        blk_q      <= cfg_blk_i;
        err_q      <= (cfg_word_i[29:28] == 2'd3);
        fin_q      <= (cfg_len_i == '0) ||
                      ((cfg_word_i[31:30] != MODE_NORMAL) && (cfg_blk_i == '0));
      end else begin
        len_q <= len_nxt;
        blk_q <= blk_nxt;
        if (fin_set) fin_q <= 1'b1;
      end

      if (load_ok || sw_stop_i || !en_i || fin_set) cont_q <= 1'b0;
      else if (cont_set) cont_q <= 1'b1;

      if (item_done) stop_q <= 1'b0;
      else if (sw_stop_i && st_q != ST_IDLE) stop_q <= 1'b1;

      unique case (st_q)
        ST_IDLE: if (start_idle) st_q <= ST_RD;
        ST_RD: begin
          if (mem_rsp_i) begin
            data_q <= mem_rdata_i;
            st_q   <= ST_WR;
          end
        end
        default: if (mem_rsp_i) st_q <= go_on ? ST_RD : ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? ptr_cur[1] : ptr_cur[0];
  assign mem_size_o  = cfg_q.size;
  assign mem_wdata_o = data_q;
  assign irq_o       = irq_q;
  assign done_o      = fin_q;
  assign err_o       = err_q;
  assign len_left_o  = len_q;
  assign blk_left_o  = blk_q;

endmodule

module dma_seq_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          cfg_load_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_rsp_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          irq_o,
  input logic          done_o,
  input logic          err_o
);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_done_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mem_req_o && !cfg_load_i) |=> !mem_req_o);

  p_irq_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_rsp_i));

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !mem_req_o) |=> !mem_req_o);

  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);

endmodule

bind dma_seq_chan dma_seq_chan_chk #(.AW(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cfg_load_i (cfg_load_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_rsp_i  (mem_rsp_i),
  .mem_addr_o (mem_addr_o),
  .irq_o      (irq_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_dma_seq_chan.sv
module sim_dma_seq_chan;

  localparam int AW = 12;
  localparam int CW = 16;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_load = 0, en = 1, trig = 0, sw_start = 0, sw_cont = 0, sw_stop = 0;
  logic [31:0]   cfg_word = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0, cfg_off = '0;
  logic [CW-1:0] cfg_len = '0, cfg_blk = '0;
  logic          mem_req, mem_we, mem_rsp, irq, done, err;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [CW-1:0] len_left, blk_left;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  dma_seq_chan #(.ADDR_W(AW), .CNT_W(CW), .PEND_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_word_i(cfg_word),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_offset_i(cfg_off),
    .cfg_len_i(cfg_len), .cfg_blk_i(cfg_blk), .en_i(en), .trig_i(trig),
    .sw_start_i(sw_start), .sw_cont_i(sw_cont), .sw_stop_i(sw_stop),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp),
    .mem_rdata_i(mem_rdata), .irq_o(irq), .done_o(done), .err_o(err),
    .len_left_o(len_left), .blk_left_o(blk_left)
  );

  // byte memory, one-cycle response
  logic [7:0] mem [256];
  logic [7:0] ma;
  assign ma = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ma + 8'd3)], mem[8'(ma + 8'd2)], mem[8'(ma + 8'd1)], mem[ma]};

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp <= 1'b0;
    end else begin
      mem_rsp <= mem_req && !mem_rsp;
      if (mem_req && !mem_rsp && mem_we)
        for (int k = 0; k < 4; k++)
          if (k < (1 << mem_size)) mem[8'(int'(ma) + k)] <= mem_wdata[k*8 +: 8];
    end
  end

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  function automatic logic [7:0] sv(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input int mode, size, sam, irqs, rep, dam);
    return {2'(mode), 2'(size), 2'(sam), 4'b0, 1'(irqs), 1'(rep), 2'(dam), 18'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] <= sv(i);
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] w, input int s, d, off, len, blk);
    @(negedge clk);
    cfg_word = w; cfg_src = AW'(s); cfg_dst = AW'(d); cfg_off = AW'(off);
    cfg_len = CW'(len); cfg_blk = CW'(blk); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic fire(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      cyc(gap);
    end
  endtask

  task automatic t_reset();
    chk("R1 req", mem_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", err, 0);
    chk("R1 done", done, 1);
    chk("R1 len", len_left, 0);
    chk("R1 blk", blk_left, 0);
  endtask

  task automatic t_normal();
    fill();
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 3, 0);
    chk("R2 not done after load", done, 0);
    fire(1, 8);
    chk("R2 len after one", len_left, 2);
    chk("R2 first byte", mem[8'h80], sv('h10));
    fire(2, 8);
    chk("R2 byte2", mem[8'h81], sv('h11));
    chk("R2 byte3", mem[8'h82], sv('h12));
    chk("R2 done", done, 1);
    fire(1, 8);
    chk("R2 ignored after end", mem[8'h83], sv('h83));
    chk("R2 len stays zero", len_left, 0);
  endtask

  task automatic t_addr();
    fill();
    load(mk(0, 1, 3, 0, 0, 1), 'h20, 'h90, 4, 2, 0);
    fire(2, 8);
    chk("R3 half lo", mem[8'h90], sv('h20));
    chk("R3 half hi", mem[8'h91], sv('h21));
    chk("R3 dec+offset lo", mem[8'h94], sv('h1E));
    chk("R3 dec+offset hi", mem[8'h95], sv('h1F));
    chk("R3 offset gap", mem[8'h92], sv('h92));
    load(mk(0, 2, 0, 0, 0, 2), 'h30, 'hA0, 0, 2, 0);
    fire(2, 8);
    for (int k = 0; k < 4; k++) begin
      chk("R3 word fixed src a", mem[8'(8'hA0 + k)], sv('h30 + k));
      chk("R3 word fixed src b", mem[8'(8'hA4 + k)], sv('h30 + k));
    end
  endtask

  task automatic t_repeat();
    fill();
    load(mk(1, 0, 2, 0, 1, 2), 'h10, 'h80, 0, 2, 2);
    fire(2, 8);
    chk("R4 len reload", len_left, 2);
    chk("R4 rounds left", blk_left, 1);
    fire(2, 8);
    chk("R4 b0", mem[8'h80], sv('h10));
    chk("R4 b1", mem[8'h81], sv('h11));
    chk("R4 src restored b2", mem[8'h82], sv('h10));
    chk("R4 src restored b3", mem[8'h83], sv('h11));
    chk("R4 done", done, 1);
    fire(1, 8);
    chk("R4 ignored after end", mem[8'h84], sv('h84));
  endtask

  task automatic t_block();
    fill();
    load(mk(2, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 2);
    fire(1, 14);
    chk("R5 blk1 b0", mem[8'h80], sv('h10));
    chk("R5 blk1 b1", mem[8'h81], sv('h11));
    chk("R5 blocks left", blk_left, 1);
    chk("R5 len reload", len_left, 2);
    chk("R5 not done", done, 0);
    fire(1, 14);
    chk("R5 dst restored b0", mem[8'h80], sv('h12));
    chk("R5 dst restored b1", mem[8'h81], sv('h13));
    chk("R5 untouched", mem[8'h82], sv('h82));
    chk("R5 done", done, 1);
  endtask

  task automatic t_ring();
    fill();
    load(mk(3, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 2);
    fire(2, 14);
    chk("R6 second block", mem[8'h80], sv('h12));
    chk("R6 count reload", blk_left, 2);
    chk("R6 never done", done, 0);
    fire(1, 14);
    chk("R6 src wrapped b0", mem[8'h80], sv('h10));
    chk("R6 src wrapped b1", mem[8'h81], sv('h11));
    chk("R6 count after wrap", blk_left, 1);
  endtask

  task automatic t_irq();
    int base;
    fill();
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 3, 0);
    base = irq_cnt;
    fire(2, 8);
    chk("R7 end-only none yet", irq_cnt - base, 0);
    fire(1, 8);
    chk("R7 end-only one", irq_cnt - base, 1);
    load(mk(0, 0, 2, 1, 0, 2), 'h10, 'h80, 0, 3, 0);
    base = irq_cnt;
    fire(3, 8);
    chk("R7 each item", irq_cnt - base, 3);
  endtask

  task automatic t_enable();
    fill();
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 0);
    @(negedge clk); en = 1'b0;
    fire(1, 8);
    chk("R8 no move", mem[8'h80], sv('h80));
    chk("R8 len kept", len_left, 2);
    @(negedge clk); en = 1'b1;
    fire(1, 8);
    chk("R8 moves after enable", mem[8'h80], sv('h10));
    chk("R8 len after enable", len_left, 1);
  endtask

  task automatic t_sw();
    logic [CW-1:0] l0, b0;
    fill();
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 4, 0);
    @(negedge clk); sw_start = 1'b1; sw_cont = 1'b1;
    @(negedge clk); sw_start = 1'b0; sw_cont = 1'b0;
    cyc(30);
    chk("R9 cont b3", mem[8'h83], sv('h13));
    chk("R9 cont done", done, 1);
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h90, 0, 3, 0);
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    cyc(10);
    chk("R9 single one item", len_left, 2);
    load(mk(3, 0, 2, 0, 0, 2), 'h10, 'hA0, 0, 2, 2);
    @(negedge clk); sw_start = 1'b1; sw_cont = 1'b1;
    @(negedge clk); sw_start = 1'b0; sw_cont = 1'b0;
    cyc(13);
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    cyc(8);
    chk("R9 halted", mem_req, 0);
    l0 = len_left; b0 = blk_left;
    cyc(20);
    chk("R9 len frozen", len_left, l0);
    chk("R9 blk frozen", blk_left, b0);
    chk("R9 still idle", mem_req, 0);
  endtask

  task automatic t_pend();
    fill();
    load(mk(2, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 3, 4);
    @(negedge clk); trig = 1'b1;
    cyc(4);
    trig = 1'b0;
    cyc(70);
    chk("R10 all blocks", blk_left, 0);
    chk("R10 done", done, 1);
    chk("R10 last block b0", mem[8'h80], sv('h19));
    chk("R10 last block b2", mem[8'h82], sv('h1B));
  endtask

  task automatic t_err();
    fill();
    load(mk(0, 3, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 0);
    chk("R11 err", err, 1);
    fire(1, 8);
    chk("R11 no move", mem[8'h80], sv('h80));
    chk("R11 len kept", len_left, 2);
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 0);
    chk("R11 err cleared", err, 0);
  endtask

  task automatic t_zero();
    fill();
    load(mk(0, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 0, 5);
    chk("R12 zero len done", done, 1);
    load(mk(2, 0, 2, 0, 0, 2), 'h10, 'h80, 0, 2, 0);
    chk("R12 zero blocks done", done, 1);
    fire(1, 10);
    chk("R12 no move", mem[8'h80], sv('h80));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_normal();
    t_addr();
    t_repeat();
    t_block();
    t_ring();
    t_irq();
    t_enable();
    t_sw();
    t_pend();
    t_err();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule